// File: doc/BRIEF.md
# PLL Relock Sequencer with Core-Interface Divider

This block walks a core-clock PLL through a frequency change. A caller hands it a new PLL control word and a one-bit flag that says whether the target core rate lies above the 500 MHz limit of the core-interface clock. The block writes the control word with its power-down and bypass bits forced low. It then waits a fixed relock interval and samples the PLL status. Finally it returns one of three outcomes: success, lock timeout or PLL error.

The block also owns the write port of the core-interface clock divider, so the interface clock is never driven above its limit. For a fast target, divide-by-2 is written before the PLL is touched. For a slow target, divide-by-1 is restored only after the PLL has relocked cleanly. On any failure the divider keeps the setting it had when the status was sampled. The relock interval is a cycle count, sized from the 100 µs lock time and the system clock frequency.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `rsp_code` is 0 and neither write strobe is active.
- R2: The PLL control word is written exactly once per accepted request. It carries the requested word with bit 0 (power-down) and bit 1 (bypass) cleared and all other bits unchanged.
- R3: When `req_fast` is 1, the divider is written with value 1 (divide-by-2) in the cycle directly before the PLL write. Counting the accept edge as cycle 0, that is cycle 1 and the PLL write is cycle 2.
- R4: When `req_fast` is 0, nothing is written to the divider before the PLL write, which happens in cycle 1. On success the divider is written with value 0 (divide-by-1) exactly once, after the status check.
- R5: Status is sampled WAIT_CYCLES+1 cycles after the PLL write cycle. The response appears one cycle after that sample, or two cycles after it when the divide-by-1 write comes in between.
- R6: If status bit 0 (lock) is 0 at the sample, the response code is 1 (timeout), whatever status bit 1 holds.
- R7: If lock is 1 and status bit 1 (error) is 1, the response code is 2 (PLL error). If lock is 1 and error is 0, the code is 0 (success).
- R8: After a timeout or an error, no divider write follows the PLL write.
- R9: `rsp_valid` is a single-cycle pulse. `rsp_code` changes only with that pulse and holds its value until the next response.
- R10: While a sequence is in progress, `req_ready` is 0 and `req_valid` has no effect: no extra PLL write, no change of the written word and no shift in response timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start request, accepted when `req_ready` is 1 |
| req_ready | output | 1 | High while idle |
| req_ctrl | input | CTRL_W | New PLL control word |
| req_fast | input | 1 | Target core rate is above the interface limit |
| pll_wr_en | output | 1 | PLL control word write strobe |
| pll_wr_data | output | CTRL_W | Control word with power-down and bypass cleared |
| pll_status | input | 2 | Bit 0 lock, bit 1 error |
| ifdiv_wr_en | output | 1 | Interface divider write strobe |
| ifdiv_wr_data | output | 1 | 1 = divide-by-2, 0 = divide-by-1 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_code | output | 2 | 0 success, 1 timeout, 2 PLL error; held |

## Verification
A fast target and a slow target are each run with a clean status. This shows the divide-by-2 pre-write apart from the divide-by-1 post-write, and exposes any swap in the write order. Status patterns of no lock, no lock with error, and lock with error separate the timeout and error codes and confirm that lock takes priority. They also show that no divider write follows a failure. A request pulsed in the middle of the wait, carrying a different word and the opposite flag, shows whether anything is accepted while busy. A control word with both low bits set shows whether the masking is applied.

// File: rtl/pll_relock_pkg.sv
package pll_relock_pkg;
   typedef enum logic [1:0] {
      RSP_OK      = 2'd0,
      RSP_TIMEOUT = 2'd1,
      RSP_FAULT   = 2'd2
   } rsp_code_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIV_PRE,
      ST_PLL_WR,
      ST_WAIT,
      ST_CHECK,
      ST_DIV_POST
   } seq_state_e;

   localparam int STAT_LOCK_BIT = 0;
   localparam int STAT_ERR_BIT  = 1;
   localparam logic IFDIV_BY1 = 1'b0;
   localparam logic IFDIV_BY2 = 1'b1;
endpackage

// File: rtl/relock_timer.sv
module relock_timer #(
   parameter int WAIT_CYCLES = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic active,
   output logic done
);
   generate
      if (WAIT_CYCLES < 1) begin : g_bad
         $error("WAIT_CYCLES must be at least 1");
      end else if (WAIT_CYCLES == 1) begin : g_single
         // a one-cycle wait needs no counter
         assign done = active;
      end else begin : g_count
         localparam int CNT_W = $clog2(WAIT_CYCLES);
         localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (load)                  cnt_q <= LOAD_VAL;
            else if (active && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end

         assign done = active && (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/relock_fsm.sv
module relock_fsm
   import pll_relock_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_fast,
   input  logic [1:0] pll_status,
   input  logic       wait_done,
   output logic       req_ready,
   output logic       capture,
   output logic       timer_load,
   output logic       timer_active,
   output logic       pll_wr_en,
   output logic       ifdiv_wr_en,
   output logic       ifdiv_wr_data,
   output logic       rsp_valid,
   output logic [1:0] rsp_code
);
   seq_state_e state_q, state_d;
   logic       fast_q;
   logic       rsp_valid_q, rsp_valid_d;
   rsp_code_e  code_q, code_d;

   wire lock_s = pll_status[STAT_LOCK_BIT];
   wire err_s  = pll_status[STAT_ERR_BIT];

   always_comb begin
      state_d     = state_q;
      rsp_valid_d = 1'b0;
      code_d      = code_q;
      unique case (state_q)
         ST_IDLE:     if (req_valid) state_d = req_fast ? ST_DIV_PRE : ST_PLL_WR;
         ST_DIV_PRE:  state_d = ST_PLL_WR;
         ST_PLL_WR:   state_d = ST_WAIT;
         ST_WAIT:     if (wait_done) state_d = ST_CHECK;
         ST_CHECK: begin
            if (!lock_s) begin
               state_d = ST_IDLE; rsp_valid_d = 1'b1; code_d = RSP_TIMEOUT;
            end else if (err_s) begin
               state_d = ST_IDLE; rsp_valid_d = 1'b1; code_d = RSP_FAULT;
            end else if (!fast_q) begin
               state_d = ST_DIV_POST;
            end else begin
               state_d = ST_IDLE; rsp_valid_d = 1'b1; code_d = RSP_OK;
            end
         end
         ST_DIV_POST: begin
            state_d = ST_IDLE; rsp_valid_d = 1'b1; code_d = RSP_OK;
         end
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         fast_q      <= 1'b0;
         rsp_valid_q <= 1'b0;
         code_q      <= RSP_OK;
      end else begin
         state_q     <= state_d;
         rsp_valid_q <= rsp_valid_d;
         code_q      <= code_d;
         if (capture) fast_q <= req_fast;
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign capture       = req_ready && req_valid;
   assign timer_load    = (state_q == ST_PLL_WR);
   assign timer_active  = (state_q == ST_WAIT);
   assign pll_wr_en     = (state_q == ST_PLL_WR);
   assign ifdiv_wr_en   = (state_q == ST_DIV_PRE) || (state_q == ST_DIV_POST);
   assign ifdiv_wr_data = (state_q == ST_DIV_PRE) ? IFDIV_BY2 : IFDIV_BY1;
   assign rsp_valid     = rsp_valid_q;
   assign rsp_code      = code_q;
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq #(
   parameter int CTRL_W      = 32,
   parameter int WAIT_CYCLES = 10000,
   parameter int PD_BIT      = 0,
   parameter int BYP_BIT     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CTRL_W-1:0] req_ctrl,
   input  logic              req_fast,
   output logic              pll_wr_en,
   output logic [CTRL_W-1:0] pll_wr_data,
   input  logic [1:0]        pll_status,
   output logic              ifdiv_wr_en,
   output logic              ifdiv_wr_data,
   output logic              rsp_valid,
   output logic [1:0]        rsp_code
);
   localparam logic [CTRL_W-1:0] CLR_MASK =
      ~((CTRL_W'(1) << PD_BIT) | (CTRL_W'(1) << BYP_BIT));

   generate
      if (CTRL_W < 2 || PD_BIT >= CTRL_W || BYP_BIT >= CTRL_W || PD_BIT == BYP_BIT) begin : g_bad
         $error("control word bit positions do not fit CTRL_W");
      end
   endgenerate

   logic              capture, timer_load, timer_active, wait_done;
   logic [CTRL_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (capture) ctrl_q <= req_ctrl & CLR_MASK;
   end

   assign pll_wr_data = ctrl_q;

   relock_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_fast      (req_fast),
      .pll_status    (pll_status),
      .wait_done     (wait_done),
      .req_ready     (req_ready),
      .capture       (capture),
      .timer_load    (timer_load),
      .timer_active  (timer_active),
      .pll_wr_en     (pll_wr_en),
      .ifdiv_wr_en   (ifdiv_wr_en),
      .ifdiv_wr_data (ifdiv_wr_data),
      .rsp_valid     (rsp_valid),
      .rsp_code      (rsp_code)
   );

   relock_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (timer_load),
      .active (timer_active),
      .done   (wait_done)
   );
endmodule

// File: rtl/pll_relock_chk.sv
module pll_relock_chk #(
   parameter int CTRL_W      = 32,
   parameter int WAIT_CYCLES = 10000,
   parameter int PD_BIT      = 0,
   parameter int BYP_BIT     = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [CTRL_W-1:0] req_ctrl,
   input logic              req_fast,
   input logic              pll_wr_en,
   input logic [CTRL_W-1:0] pll_wr_data,
   input logic [1:0]        pll_status,
   input logic              ifdiv_wr_en,
   input logic              ifdiv_wr_data,
   input logic              rsp_valid,
   input logic [1:0]        rsp_code
);
   logic [31:0] since_wr;
   logic        seen_wr;

   // cycles since the latest PLL write, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_wr <= '0;
         seen_wr  <= 1'b0;
      end else if (pll_wr_en) begin
         since_wr <= '0;
         seen_wr  <= 1'b1;
      end else if (since_wr != '1) begin
         since_wr <= since_wr + 1'b1;
      end
   end

   assert_pd_byp_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pll_wr_en |-> (pll_wr_data[PD_BIT] == 1'b0 && pll_wr_data[BYP_BIT] == 1'b0));

   assert_div2_before_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ifdiv_wr_en && ifdiv_wr_data) |=> pll_wr_en);

   assert_div1_then_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ifdiv_wr_en && !ifdiv_wr_data) |=> (rsp_valid && rsp_code == 2'd0));

   assert_wait_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (seen_wr && since_wr >= 32'(WAIT_CYCLES + 1)));

   assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> $stable(rsp_code));

   assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_wr_en || ifdiv_wr_en) |-> !req_ready);

   assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_code != 2'd3);
endmodule

bind pll_relock_seq pll_relock_chk #(
   .CTRL_W(CTRL_W), .WAIT_CYCLES(WAIT_CYCLES), .PD_BIT(PD_BIT), .BYP_BIT(BYP_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_ctrl(req_ctrl), .req_fast(req_fast), .pll_wr_en(pll_wr_en),
   .pll_wr_data(pll_wr_data), .pll_status(pll_status), .ifdiv_wr_en(ifdiv_wr_en),
   .ifdiv_wr_data(ifdiv_wr_data), .rsp_valid(rsp_valid), .rsp_code(rsp_code)
);

// File: tb/pll_relock_seq_bench.sv
module pll_relock_seq_bench;
   localparam int W = 8;
   localparam int CW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [CW-1:0] req_ctrl = '0;
   logic          req_fast = 1'b0;
   logic          pll_wr_en;
   logic [CW-1:0] pll_wr_data;
   logic [1:0]    pll_status = 2'b00;
   logic          ifdiv_wr_en;
   logic          ifdiv_wr_data;
   logic          rsp_valid;
   logic [1:0]    rsp_code;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pll_relock_seq #(.CTRL_W(CW), .WAIT_CYCLES(W)) u_pll_relock_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ctrl(req_ctrl), .req_fast(req_fast), .pll_wr_en(pll_wr_en),
      .pll_wr_data(pll_wr_data), .pll_status(pll_status), .ifdiv_wr_en(ifdiv_wr_en),
      .ifdiv_wr_data(ifdiv_wr_data), .rsp_valid(rsp_valid), .rsp_code(rsp_code)
   );

   // observations of one sequence
   int          o_pll_n, o_pll_cyc, o_pre_n, o_pre_cyc, o_post_n, o_post_cyc;
   int          o_rsp_n, o_rsp_cyc, o_ready_busy;
   logic [CW-1:0] o_pll_data;
   logic        o_pre_data, o_post_data;
   logic [1:0]  o_rsp_code, o_code_after;

   task automatic check(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run_seq(input logic [CW-1:0] ctrl, input logic fast,
                          input logic [1:0] status, input bit poke);
      o_pll_n = 0; o_pll_cyc = 0; o_pre_n = 0; o_pre_cyc = 0; o_post_n = 0;
      o_post_cyc = 0; o_rsp_n = 0; o_rsp_cyc = 0; o_ready_busy = 0;
      o_pll_data = '0; o_pre_data = 1'b0; o_post_data = 1'b0; o_rsp_code = 2'b11;
      pll_status = status;
      @(negedge clk);
      req_valid = 1'b1; req_ctrl = ctrl; req_fast = fast;
      for (int n = 1; n <= W + 12; n++) begin
         @(negedge clk);
         if (n == 1) req_valid = 1'b0;
         if (pll_wr_en) begin o_pll_n++; o_pll_cyc = n; o_pll_data = pll_wr_data; end
         if (ifdiv_wr_en) begin
            if (o_pll_n == 0) begin o_pre_n++; o_pre_cyc = n; o_pre_data = ifdiv_wr_data; end
            else begin o_post_n++; o_post_cyc = n; o_post_data = ifdiv_wr_data; end
         end
         if (rsp_valid) begin o_rsp_n++; o_rsp_cyc = n; o_rsp_code = rsp_code; end
         if (o_rsp_n == 0 && req_ready) o_ready_busy++;
         if (poke && n == 3) begin
            req_valid = 1'b1; req_ctrl = ~ctrl; req_fast = ~fast;
         end
         if (poke && n == 4) req_valid = 1'b0;
      end
      o_code_after = rsp_code;
   endtask

   task automatic t_reset();
      check("R1 req_ready", req_ready, 1);
      check("R1 rsp_valid", rsp_valid, 0);
      check("R1 rsp_code", rsp_code, 0);
      check("R1 pll_wr_en", pll_wr_en, 0);
      check("R1 ifdiv_wr_en", ifdiv_wr_en, 0);
   endtask

   task automatic t_fast_ok();
      run_seq(32'h1234_5670, 1'b1, 2'b01, 0);
      check("R3 pre-write count", o_pre_n, 1);
      check("R3 pre-write cycle", o_pre_cyc, 1);
      check("R3 pre-write value", o_pre_data, 1);
      check("R3 pll cycle", o_pll_cyc, 2);
      check("R2 pll write count", o_pll_n, 1);
      check("R5 fast rsp cycle", o_rsp_cyc, 2 + W + 2);
      check("R7 ok code", o_rsp_code, 0);
      check("R3 no post-write", o_post_n, 0);
      check("R9 single pulse", o_rsp_n, 1);
   endtask

   task automatic t_slow_ok_masked();
      run_seq(32'hA5A5_5A5F, 1'b0, 2'b01, 0);
      check("R2 masked word", o_pll_data, 32'hA5A5_5A5C);
      check("R4 no pre-write", o_pre_n, 0);
      check("R4 pll cycle", o_pll_cyc, 1);
      check("R4 post-write count", o_post_n, 1);
      check("R4 post-write value", o_post_data, 0);
      check("R5 post-write cycle", o_post_cyc, 1 + W + 2);
      check("R5 slow rsp cycle", o_rsp_cyc, 1 + W + 3);
      check("R7 ok code", o_rsp_code, 0);
   endtask

   task automatic t_timeout();
      run_seq(32'h0000_0F00, 1'b0, 2'b00, 0);
      check("R6 timeout code", o_rsp_code, 1);
      check("R8 no divider write on timeout", o_post_n + o_pre_n, 0);
      check("R5 fail rsp cycle", o_rsp_cyc, 1 + W + 2);
      check("R9 code held", o_code_after, 1);
   endtask

   task automatic t_timeout_with_err();
      run_seq(32'h0000_0F00, 1'b1, 2'b10, 0);
      check("R6 lock priority code", o_rsp_code, 1);
      check("R8 no post-write", o_post_n, 0);
   endtask

   task automatic t_fault();
      run_seq(32'hFFFF_0003, 1'b0, 2'b11, 0);
      check("R7 error code", o_rsp_code, 2);
      check("R8 no divider write on error", o_post_n, 0);
      check("R2 masked word", o_pll_data, 32'hFFFF_0000);
      check("R9 code held", o_code_after, 2);
   endtask

   task automatic t_busy_ignore();
      run_seq(32'h0BAD_CAF0, 1'b0, 2'b01, 1);
      check("R10 pll write count", o_pll_n, 1);
      check("R10 word kept", o_pll_data, 32'h0BAD_CAF0);
      check("R10 not ready while busy", o_ready_busy, 0);
      check("R10 rsp cycle kept", o_rsp_cyc, 1 + W + 3);
      check("R10 divider pattern kept", o_post_n * 10 + o_pre_n, 10);
      check("R9 code updated to ok", o_code_after, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fast_ok();
      t_slow_ok_masked();
      t_timeout();
      t_timeout_with_err();
      t_fault();
      t_busy_ignore();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule